// File: doc/BRIEF.md
# Condition-Code Generating 16-bit ALU

This block is the arithmetic core of a small minicomputer-style datapath. A single combinational path takes an operation code, a byte/word select, a source and a destination operand, and returns the result word. It also returns the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). Each operation follows its own flag rules, so the block also gives a per-flag update mask. A flag that an operation does not touch keeps its old value.

A four-bit flag register sits next to the ALU. It feeds the current carry back into the operations that consume it. When an operation is presented with `valid_i` high, the register loads only the flags enabled in the mask. The surrounding datapath uses `write_o` to decide whether the result goes back to the destination. The compare operation clears it, so compare affects only the flags.

Top module: `alu_cc_unit`

## Requirements
- R1: ADD (op 0) returns dst+src. C is the carry out of the top bit. V is set on signed overflow. N is the top result bit and Z is set for a zero result.
- R2: SUB (op 1) returns dst-src. C is set when an unsigned borrow occurs, which is the inverse of the complement-and-add carry. V is set when the operands differ in sign and the subtrahend's sign equals the result's sign.
- R3: CMP (op 2) computes src-dst and sets N, Z, V and C by the R2 rules, with dst as the subtrahend. `write_o` is 0 for CMP.
- R4: INC (op 3) returns dst+1 and DEC (op 4) returns dst-1. Neither updates C. INC sets V when dst is the largest positive value. DEC sets V when dst is the most negative value.
- R5: SBC (op 5) returns dst minus the stored C. V is set only when dst is the most negative value and the stored C is 1. C is set only when dst is zero and the stored C is 1.
- R6: COM (op 6) returns the bitwise complement of dst, clears V and sets C.
- R7: SWAB (op 7) always works on the whole word, whatever `byte_i` says. It exchanges the two bytes of dst. N and Z come from the low byte of the result, and V and C are cleared.
- R8: MOVB (op 8) sign-extends src bits 7:0 to 16 bits. N and Z come from that byte, V is cleared and C is not updated.
- R9: ASRB (op 9) shifts dst bits 7:0 right by one and keeps bit 7. Bit 0 goes to C, bits 15:8 pass from dst, N and Z come from the low byte, and V = N xor C.
- R10: With `byte_i`=1, ops 0 to 6 work on bits 7:0 only. N is taken from bit 7, Z from bits 7:0, and C and V from the 8-bit operation. Result bits 15:8 equal dst bits 15:8.
- R11: `flags_o` packs N,Z,V,C as bits 3,2,1,0. A synchronous reset clears it to 0. On a clock edge with `valid_i`=1, a flag loads its new value only when its bit in `flag_upd_o` is 1. With `valid_i`=0 no flag changes.
- R12: Op codes 10 to 15 have no effect: `write_o` is 0 and `flag_upd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| valid_i | input | 1 | Commit enabled flags at this edge |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| result_o | output | 16 | Operation result |
| write_o | output | 1 | Result should be written back |
| flag_upd_o | output | 4 | Per-flag update enable {N,Z,V,C} |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |

## Verification
On every cycle, the assertions check these properties:
- compare never requests a write-back;
- INC and DEC leave the stored carry unchanged;
- byte operations preserve the upper byte;
- MOVB output is a true sign extension;
- the stored Z flag matches a zero word result;
- any flag without an update enable holds its value.

Only the bench scenarios can show the exact boundary values. These are overflow at the largest positive and most negative operands, borrow versus carry polarity, and the SBC cases that depend on the incoming carry. The scenarios also cover the SWAB and ASRB byte-field results.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_SBC  = 4'd5,
        OP_COM  = 4'd6,
        OP_SWAB = 4'd7,
        OP_MOVB = 4'd8,
        OP_ASRB = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    // True for the operations that run through the adder
    function automatic logic is_arith(alu_op_e op);
        return op inside {OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC, OP_SBC};
    endfunction

    // True for operations that honour the byte/word select
    function automatic logic is_sized(alu_op_e op);
        return is_arith(op) || (op == OP_COM);
    endfunction

    // Which flags an operation writes
    function automatic cc_t update_mask(logic [3:0] code);
        cc_t m;
        m = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
        if (code > 4'd9) begin
            m = '0;
        end else if (alu_op_e'(code) inside {OP_INC, OP_DEC, OP_MOVB}) begin
            m.c = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/alu_cc_adder.sv
module alu_cc_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        // Same-signed inputs giving a differently signed sum
        ovf_o  = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
    import alu_cc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic [3:0]   op_i,
    input  logic         byte_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  cc_t          cur_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output cc_t          nxt_o,
    output cc_t          upd_o
);
    localparam int HI = W - BW;

    alu_op_e       op;
    logic [W-1:0]  opa, opb;
    logic          cin;
    logic [W-1:0]  sum_w;
    logic          cout_w, ovf_w;
    logic [BW-1:0] sum_b;
    logic          cout_b, ovf_b;

    assign op = alu_op_e'(op_i);

    // Operand steering: every arithmetic op is a + b + cin
    always_comb begin
        opa = dst_i;
        opb = '0;
        cin = 1'b0;
        case (op)
            OP_ADD: opb = src_i;
            OP_SUB: begin opb = ~src_i; cin = 1'b1; end
            OP_CMP: begin opa = src_i; opb = ~dst_i; cin = 1'b1; end
            OP_INC: cin = 1'b1;
            OP_DEC: opb = '1;
            OP_SBC: opb = {W{cur_i.c}};
            default: ;
        endcase
    end

    alu_cc_adder #(.W(W)) u_add_word (
        .a_i(opa), .b_i(opb), .cin_i(cin),
        .sum_o(sum_w), .cout_o(cout_w), .ovf_o(ovf_w)
    );

    alu_cc_adder #(.W(BW)) u_add_byte (
        .a_i(opa[BW-1:0]), .b_i(opb[BW-1:0]), .cin_i(cin),
        .sum_o(sum_b), .cout_o(cout_b), .ovf_o(ovf_b)
    );

    logic narrow;
    logic carry, ovf;

    always_comb begin
        narrow = byte_i && is_sized(op);
        carry  = byte_i ? cout_b : cout_w;
        ovf    = byte_i ? ovf_b  : ovf_w;
        res_o  = byte_i ? {dst_i[W-1:BW], sum_b} : sum_w;
        wr_o   = 1'b1;
        nxt_o  = cur_i;
        nxt_o.v = ovf;
        nxt_o.c = carry;
        upd_o  = update_mask(op_i);
        case (op)
            OP_SUB: nxt_o.c = ~carry;
            OP_CMP: begin nxt_o.c = ~carry; wr_o = 1'b0; end
            OP_SBC: nxt_o.c = cur_i.c & ~carry;
            OP_COM: begin
                res_o = byte_i ? {dst_i[W-1:BW], ~dst_i[BW-1:0]} : ~dst_i;
                nxt_o.v = 1'b0;
                nxt_o.c = 1'b1;
            end
            OP_SWAB: begin
                narrow  = 1'b1;
                res_o   = {dst_i[BW-1:0], dst_i[W-1:BW]};
                nxt_o.v = 1'b0;
                nxt_o.c = 1'b0;
            end
            OP_MOVB: begin
                narrow  = 1'b1;
                res_o   = {{HI{src_i[BW-1]}}, src_i[BW-1:0]};
                nxt_o.v = 1'b0;
                nxt_o.c = cur_i.c;
            end
            OP_ASRB: begin
                narrow  = 1'b1;
                res_o   = {dst_i[W-1:BW], dst_i[BW-1], dst_i[BW-1:1]};
                nxt_o.c = dst_i[0];
                nxt_o.v = dst_i[BW-1] ^ dst_i[0];
            end
            OP_ADD, OP_INC, OP_DEC: ;
            default: begin
                res_o = dst_i;
                wr_o  = 1'b0;
                nxt_o = cur_i;
            end
        endcase
        nxt_o.n = narrow ? res_o[BW-1] : res_o[W-1];
        nxt_o.z = narrow ? (res_o[BW-1:0] == '0) : (res_o == '0);
    end
endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [N-1:0] upd_i,
    input  logic [N-1:0] nxt_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[i] <= 1'b0;
            end else if (valid_i && upd_i[i]) begin
                q_o[i] <= nxt_i[i];
            end
        end

        // R11: a flag without an enabled update holds
        assert_flag_hold_R11: assert property (@(posedge clk) disable iff (rst)
            !(valid_i && upd_i[i]) |=> q_o[i] == $past(q_o[i]));
    end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [3:0]   op_i,
    input  logic         byte_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic [W-1:0] result_o,
    output logic         write_o,
    output logic [3:0]   flag_upd_o,
    output logic [3:0]   flags_o
);
    localparam int HI = W - BW;

    cc_t cur, nxt, upd;

    assign cur        = cc_t'(flags_o);
    assign flag_upd_o = upd;

    alu_cc_core #(.W(W), .BW(BW)) u_core (
        .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .cur_i(cur), .res_o(result_o), .wr_o(write_o),
        .nxt_o(nxt), .upd_o(upd)
    );

    alu_cc_flagreg #(.N(NFLAG)) u_flags (
        .clk(clk), .rst(rst), .valid_i(valid_i),
        .upd_i(upd), .nxt_i(nxt), .q_o(flags_o)
    );

    assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CMP |-> !write_o);

    assert_carry_kept_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[0] == $past(flags_o[0]));

    assert_word_zero_R1: assert property (@(posedge clk) disable iff (rst)
        valid_i && !byte_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_INC || op_i == OP_DEC)
        |=> flags_o[2] == ($past(result_o) == '0));

    assert_movb_sext_R8: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_MOVB |-> result_o[W-1:BW] == {HI{result_o[BW-1]}});

    assert_hi_byte_kept_R10: assert property (@(posedge clk) disable iff (rst)
        byte_i && op_i <= OP_COM |-> result_o[W-1:BW] == dst_i[W-1:BW]);

    assert_unused_idle_R12: assert property (@(posedge clk) disable iff (rst)
        op_i > OP_ASRB |-> !write_o && flag_upd_o == 4'b0000);
endmodule

// File: tb/tb_alu_cc_unit.sv
module tb_alu_cc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] result_o;
    logic        write_o;
    logic [3:0]  flag_upd_o;
    logic [3:0]  flags_o;

    always #10 clk = ~clk;   // 50 MHz

    alu_cc_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .byte_i(byte_i),
        .src_i(src_i), .dst_i(dst_i), .result_o(result_o), .write_o(write_o),
        .flag_upd_o(flag_upd_o), .flags_o(flags_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] model_flags = 4'b0000;

    logic [15:0] q_res[$];
    logic        q_wr[$];
    logic [3:0]  q_upd[$];
    logic [3:0]  q_flags[$];
    string       q_tag[$];

    // Reference model built from the requirement text
    task automatic model(input logic [3:0] op, input logic b, input logic [15:0] s,
                         input logic [15:0] d, input logic [3:0] cur,
                         output logic [15:0] res, output logic wr,
                         output logic [3:0] nf, output logic [3:0] upd);
        int w;
        logic [16:0] mask, msbit, r;
        logic n, z, v, c;
        logic [16:0] dd, ss;
        w = b ? 8 : 16;
        mask = b ? 17'h000FF : 17'h0FFFF;
        msbit = b ? 17'h00080 : 17'h08000;
        dd = {1'b0, d} & mask;
        ss = {1'b0, s} & mask;
        wr = 1'b1; upd = 4'b1111; v = 0; c = cur[0]; r = 0;
        case (op)
            4'd0: begin r = dd + ss; c = r[w] == 1'b1;
                  v = ((dd & msbit) == (ss & msbit)) && ((r & msbit) != (dd & msbit)); end
            4'd1: begin r = dd - ss; c = ss > dd;
                  v = ((dd & msbit) != (ss & msbit)) && ((r & msbit) == (ss & msbit)); end
            4'd2: begin r = ss - dd; c = dd > ss; wr = 1'b0;
                  v = ((dd & msbit) != (ss & msbit)) && ((r & msbit) == (dd & msbit)); end
            4'd3: begin r = dd + 1; v = dd == msbit - 1; upd = 4'b1110; end
            4'd4: begin r = dd - 1; v = dd == msbit; upd = 4'b1110; end
            4'd5: begin r = dd - cur[0]; v = (dd == msbit) && cur[0]; c = (dd == 0) && cur[0]; end
            4'd6: begin r = ~dd; v = 0; c = 1; end
            default: ;
        endcase
        r = r & mask;
        n = (r & msbit) != 0;
        z = r == 0;
        res = b ? {d[15:8], r[7:0]} : r[15:0];
        case (op)
            4'd7: begin res = {d[7:0], d[15:8]}; n = res[7]; z = res[7:0] == 0; v = 0; c = 0; end
            4'd8: begin res = {{8{s[7]}}, s[7:0]}; n = s[7]; z = s[7:0] == 0; v = 0; upd = 4'b1110; end
            4'd9: begin res = {d[15:8], d[7], d[7:1]}; c = d[0]; n = d[7]; z = res[7:0] == 0; v = n ^ c; end
            default: if (op > 4'd9) begin res = d; wr = 0; upd = 4'b0000; end
        endcase
        nf = {n, z, v, c};
    endtask

    // Driver: apply one operation and queue its expectation
    task automatic apply(input logic [3:0] op, input logic b, input logic [15:0] s,
                         input logic [15:0] d, input logic vld, input string tag);
        logic [15:0] er; logic ew; logic [3:0] ef, eu, nxt;
        @(negedge clk);
        model(op, b, s, d, model_flags, er, ew, ef, eu);
        nxt = model_flags;
        if (vld) for (int i = 0; i < 4; i++) if (eu[i]) nxt[i] = ef[i];
        model_flags = nxt;
        op_i = op; byte_i = b; src_i = s; dst_i = d; valid_i = vld;
        q_res.push_back(er); q_wr.push_back(ew); q_upd.push_back(eu);
        q_flags.push_back(nxt); q_tag.push_back(tag);
    endtask

    // Monitor: results before the edge, stored flags after it
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q_res.size() > 0) begin
                logic [15:0] er; logic ew; logic [3:0] eu, ef; string tg;
                logic [15:0] ar; logic aw; logic [3:0] au;
                er = q_res.pop_front(); ew = q_wr.pop_front(); eu = q_upd.pop_front();
                ef = q_flags.pop_front(); tg = q_tag.pop_front();
                ar = result_o; aw = write_o; au = flag_upd_o;
                @(posedge clk);
                #1;
                checks++;
                if (ar !== er || aw !== ew || au !== eu || flags_o !== ef) begin
                    errors++;
                    $display("FAIL %s: res=%h wr=%b upd=%b flags=%b expected res=%h wr=%b upd=%b flags=%b",
                             tg, ar, aw, au, flags_o, er, ew, eu, ef);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (flags_o !== 4'b0000) begin
            errors++;
            $display("FAIL R11 reset: flags=%b expected 0000", flags_o);
        end
        @(negedge clk);
        rst = 1'b0;

        apply(4'd0, 0, 16'h0001, 16'h7FFF, 1, "R1 add overflow");
        apply(4'd0, 0, 16'h0001, 16'hFFFF, 1, "R1 add carry zero");
        apply(4'd0, 1, 16'h0001, 16'h12FF, 1, "R10 byte add carry");
        apply(4'd1, 0, 16'h0007, 16'h0005, 1, "R2 sub borrow");
        apply(4'd1, 0, 16'h0001, 16'h8000, 1, "R2 sub overflow");
        apply(4'd2, 0, 16'h0003, 16'h0003, 1, "R3 cmp equal");
        apply(4'd2, 0, 16'h8000, 16'h0001, 1, "R3 cmp overflow");
        apply(4'd0, 0, 16'h8000, 16'h8000, 1, "R1 set carry");
        apply(4'd3, 0, 16'h0000, 16'h7FFF, 1, "R4 inc max keeps C");
        apply(4'd4, 0, 16'h0000, 16'h8000, 1, "R4 dec min keeps C");
        apply(4'd0, 0, 16'hFFFF, 16'h0001, 1, "R1 set carry again");
        apply(4'd5, 0, 16'h0000, 16'h8000, 1, "R5 sbc min with C");
        apply(4'd0, 0, 16'hFFFF, 16'h0001, 1, "R1 set carry third");
        apply(4'd5, 0, 16'h0000, 16'h0000, 1, "R5 sbc zero with C");
        apply(4'd1, 0, 16'h0000, 16'h0004, 1, "R2 clear carry");
        apply(4'd5, 0, 16'h0000, 16'h8000, 1, "R5 sbc min no C");
        apply(4'd6, 0, 16'h0000, 16'h00F0, 1, "R6 com word");
        apply(4'd6, 1, 16'h0000, 16'hA5FF, 1, "R10 com byte");
        apply(4'd7, 1, 16'h0000, 16'h1280, 1, "R7 swab byte flag ignored");
        apply(4'd7, 0, 16'h0000, 16'h00FF, 1, "R7 swab zero low");
        apply(4'd8, 0, 16'h0080, 16'h1234, 1, "R8 movb negative");
        apply(4'd8, 1, 16'hAB7F, 16'h0000, 1, "R8 movb positive");
        apply(4'd9, 0, 16'h0000, 16'h3481, 1, "R9 asrb negative odd");
        apply(4'd9, 0, 16'h0000, 16'h5502, 1, "R9 asrb even");
        apply(4'd4, 1, 16'h0000, 16'h3380, 1, "R10 byte dec min");
        apply(4'd0, 0, 16'h0001, 16'hFFFF, 0, "R11 invalid holds");
        apply(4'd12, 0, 16'h1111, 16'h2222, 1, "R12 unused code");
        apply(4'd15, 1, 16'h0000, 16'h0000, 1, "R12 unused code top");

        @(negedge clk);
        valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule